// File: doc/BRIEF.md
# Vector-Width Frequency License Controller

This block sits beside one hardware thread and looks at every retired instruction it reports. Each report gives the vector width of the instruction and whether it is a heavy operation (floating-point math or integer multiply) or a light one. From this stream the controller picks a frequency license for a clock governor. There are three levels. Level 0 allows the full clock. Level 1 allows roughly 85% of it. Level 2 allows roughly 60% of it.

Some instruction classes raise the level on the first occurrence, which is a hard trigger. Others raise it only after a programmable number of occurrences, which is a soft trigger. A programmable quiet period with no qualifying instruction brings the level down one step at a time. A disable input pins the license at level 0. The two programmable values are loaded together through a configuration strobe. They reset to 16 instructions and 1024 cycles.

The state machine has three states: `ST_FULL` (level 0), `ST_MID` (level 1) and `ST_LOW` (level 2). It has these transitions:
- `ST_FULL→ST_LOW`: the heavy-512 count reaches the threshold.
- `ST_FULL→ST_MID`: a light-512 instruction arrives, or the heavy-256 count reaches the threshold.
- `ST_MID→ST_LOW`: the heavy-512 count reaches the threshold.
- `ST_MID→ST_FULL` and `ST_LOW→ST_MID`: the quiet period expires.
- Any state to `ST_FULL`: the disable input is high.

Top module: `vlic_ctrl`

## Requirements
- R1: After reset the level is 0, the change strobe is low, the soft threshold is 16 instructions and the quiet period is 1024 cycles.
- R2: Width code 2'b00 is 128-bit, 2'b01 is 256-bit, 2'b10 is 512-bit and 2'b11 is reserved. Any 128-bit instruction, a light 256-bit instruction and any reserved-width instruction never raise the level. They also never restart the quiet period.
- R3: A valid light 512-bit instruction (heavy bit 0) raises level 0 to level 1 at the clock edge that samples it.
- R4: At level 0, the Nth valid heavy 256-bit instruction raises the level to 1, where N is the soft threshold. The (N-1)th instruction leaves the level at 0.
- R5: At level 0 or 1, the Nth valid heavy 512-bit instruction raises the level to 2. The change is made directly from level 0 when that is the current level.
- R6: When the level is above 0, it falls by exactly one level at the edge that completes a run of quiet-period cycles with no qualifying instruction. The run is counted from the last qualifying instruction or the last step down.
- R7: At level L, an instruction qualifies when it would demand a level of at least L, with L at least 1. At level 2, a stream of light 512-bit instructions therefore lets the level fall to 1, and then holds it at 1.
- R8: Both soft counts clear whenever the level changes. They also clear when the quiet period expires at level 0.
- R9: While the disable input is high, the level is 0 from the next edge onward. No instruction raises it while the input stays high.
- R10: The change strobe is high for exactly the one cycle after each edge at which the level changed.
- R11: A configuration load replaces the threshold and the quiet period. The new values act from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Load strobe for cfg_thresh and cfg_quiet |
| cfg_thresh | input | THRESH_W | Soft trigger threshold in instructions |
| cfg_quiet | input | QUIET_W | Quiet period in cycles |
| cfg_disable | input | 1 | Forces level 0 and blocks every raise |
| ins_valid | input | 1 | A retired-instruction descriptor is present |
| ins_width | input | 2 | Vector width code (R2) |
| ins_heavy | input | 1 | 1 = heavy class, 0 = light class |
| lic_level | output | 2 | Current license level, 0 to 2 |
| lic_change | output | 1 | One-cycle strobe after a level change |

## Verification
The assertions assume at most one descriptor per cycle. They assume the width, heavy and valid inputs are settled at every sampling edge, and that the disable input is never X after reset. The hard-raise and hold checks only apply while the disable input is low, because disable overrides them. The bench drives every input on the falling edge. It holds ins_valid at a known value in every cycle and toggles cfg_disable only between descriptors. A new threshold and quiet period are loaded only while the level is 0, so that no window in flight changes length under a check.

// File: rtl/vlic_pkg.sv
package vlic_pkg;
    typedef enum logic [1:0] {
        VW_128  = 2'b00,
        VW_256  = 2'b01,
        VW_512  = 2'b10,
        VW_RSVD = 2'b11
    } vwidth_e;

    typedef enum logic [1:0] {
        ST_FULL = 2'd0,
        ST_MID  = 2'd1,
        ST_LOW  = 2'd2
    } lic_state_e;

    typedef struct packed {
        logic hard1;
        logic soft1;
        logic soft2;
    } demand_t;

    localparam int NUM_SOFT = 2;
endpackage

// File: rtl/vlic_classify.sv
module vlic_classify
    import vlic_pkg::*;
(
    input  logic       ins_valid,
    input  logic [1:0] ins_width,
    input  logic       ins_heavy,
    output demand_t    dem,
    output logic [1:0] need
);
    always_comb begin
        dem = '0;
        if (ins_valid) begin
            unique case (vwidth_e'(ins_width))
                VW_256: dem.soft1 = ins_heavy;
                VW_512: begin
                    dem.soft2 = ins_heavy;
                    dem.hard1 = !ins_heavy;
                end
                VW_128, VW_RSVD: dem = '0;
                default: dem = '0;
            endcase
        end
        if (dem.soft2)
            need = 2'd2;
        else if (dem.soft1 || dem.hard1)
            need = 2'd1;
        else
            need = 2'd0;
    end
endmodule

// File: rtl/vlic_soft_cnt.sv
module vlic_soft_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] thresh,
    output logic          hit
);
    localparam int EW = CW + 1;

    logic [CW-1:0] cnt;

    assign hit = inc && (({1'b0, cnt} + EW'(1)) >= {1'b0, thresh});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && (cnt != {CW{1'b1}}))
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/vlic_quiet_timer.sv
module vlic_quiet_timer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [QW-1:0] quiet_len,
    output logic          expire
);
    localparam int EW = QW + 1;

    logic [QW-1:0] q;

    assign expire = !restart && (({1'b0, q} + EW'(1)) >= {1'b0, quiet_len});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (restart || expire)
            q <= '0;
        else if (q != {QW{1'b1}})
            q <= q + QW'(1);
    end
endmodule

// File: rtl/vlic_ctrl.sv
module vlic_ctrl
    import vlic_pkg::*;
#(
    parameter int THRESH_W   = 8,
    parameter int QUIET_W    = 16,
    parameter int THRESH_RST = 16,
    parameter int QUIET_RST  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [THRESH_W-1:0] cfg_thresh,
    input  logic [QUIET_W-1:0]  cfg_quiet,
    input  logic                cfg_disable,
    input  logic                ins_valid,
    input  logic [1:0]          ins_width,
    input  logic                ins_heavy,
    output logic [1:0]          lic_level,
    output logic                lic_change
);
    logic [THRESH_W-1:0] thresh_q;
    logic [QUIET_W-1:0]  quiet_q;
    lic_state_e          state, nxt;
    logic                chg_q;
    demand_t             dem;
    logic [1:0]          need;
    logic                qualify, expire, lvl_move, soft_clr;
    logic [NUM_SOFT-1:0] hit;

    // programmable window settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh_q <= THRESH_W'(THRESH_RST);
            quiet_q  <= QUIET_W'(QUIET_RST);
        end else if (cfg_load) begin
            thresh_q <= cfg_thresh;
            quiet_q  <= cfg_quiet;
        end
    end

    vlic_classify u_cls (
        .ins_valid (ins_valid),
        .ins_width (ins_width),
        .ins_heavy (ins_heavy),
        .dem       (dem),
        .need      (need)
    );

    // an instruction keeps the current level alive when it demands at least that level
    assign qualify = (need != 2'd0) && (need >= 2'(state));

    vlic_quiet_timer #(.QW(QUIET_W)) u_quiet (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (qualify || cfg_disable),
        .quiet_len (quiet_q),
        .expire    (expire)
    );

    assign lvl_move = (nxt != state);
    assign soft_clr = lvl_move || cfg_disable || (expire && (state == ST_FULL));

    generate
        for (genvar g = 0; g < NUM_SOFT; g++) begin : g_soft
            localparam lic_state_e TGT = lic_state_e'(2'(g + 1));
            logic match;
            assign match = (g == 0) ? dem.soft1 : dem.soft2;
            vlic_soft_cnt #(.CW(THRESH_W)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (soft_clr),
                .inc    (match && (state < TGT) && !cfg_disable),
                .thresh (thresh_q),
                .hit    (hit[g])
            );
        end
    endgenerate

    // next-state decision
    always_comb begin
        nxt = state;
        if (cfg_disable) begin
            nxt = ST_FULL;
        end else begin
            unique case (state)
                ST_FULL: begin
                    if (hit[1])
                        nxt = ST_LOW;
                    else if (hit[0] || dem.hard1)
                        nxt = ST_MID;
                end
                ST_MID: begin
                    if (hit[1])
                        nxt = ST_LOW;
                    else if (expire)
                        nxt = ST_FULL;
                end
                ST_LOW: begin
                    if (expire)
                        nxt = ST_MID;
                end
                default: nxt = ST_FULL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FULL;
            chg_q <= 1'b0;
        end else begin
            state <= nxt;
            chg_q <= lvl_move;
        end
    end

    // outputs
    always_comb begin
        lic_level  = 2'(state);
        lic_change = chg_q;
    end

    AST_DISABLE_FORCES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_disable |=> (lic_level == 2'd0)); // R9
    AST_HARD_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_width == 2'b10 && !ins_heavy && !cfg_disable) |=> (lic_level != 2'd0)); // R3
    AST_PASSIVE_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (ins_width == 2'b00 || (ins_width == 2'b01 && !ins_heavy)) && lic_level == 2'd0)
        |=> (lic_level == 2'd0)); // R2
    AST_HEAVY_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_width == 2'b10 && ins_heavy && lic_level == 2'd2 && !cfg_disable)
        |=> (lic_level == 2'd2)); // R7
    AST_STEP_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_disable) && (lic_level < $past(lic_level)))
        |-> (($past(lic_level) - lic_level) == 2'd1)); // R6
    AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lic_change == (lic_level != $past(lic_level))); // R10
endmodule

// File: tb/tb_vlic_ctrl.sv
`timescale 1ns/1ps
module tb_vlic_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_load, cfg_disable;
    logic [7:0] cfg_thresh;
    logic [15:0] cfg_quiet;
    logic       ins_valid, ins_heavy;
    logic [1:0] ins_width;
    logic [1:0] lic_level;
    logic       lic_change;

    always #2.5 clk = ~clk;

    vlic_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_thresh(cfg_thresh),
        .cfg_quiet(cfg_quiet), .cfg_disable(cfg_disable), .ins_valid(ins_valid),
        .ins_width(ins_width), .ins_heavy(ins_heavy),
        .lic_level(lic_level), .lic_change(lic_change)
    );

    typedef struct {
        int         at;
        logic [1:0] lvl;
        logic       chg;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops due expectations and compares
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            checks++;
            if (e.at != cyc || lic_level !== e.lvl || lic_change !== e.chg) begin
                fails++;
                $display("FAIL %s cyc=%0d level=%0d exp=%0d change=%0d exp=%0d",
                         e.req, cyc, lic_level, e.lvl, lic_change, e.chg);
            end
        end
    end

    task automatic drive(input logic v, input logic [1:0] w, input logic h,
                         input logic [1:0] lvl, input logic chg, input string req);
        ins_valid = v; ins_width = w; ins_heavy = h;
        sb.push_back('{cyc + 1, lvl, chg, req});
        @(negedge clk);
    endtask

    task automatic rep(input int n, input logic [1:0] w, input logic h,
                       input logic [1:0] lvl, input string req);
        for (int i = 0; i < n; i++) drive(1'b1, w, h, lvl, 1'b0, req);
    endtask

    task automatic quiet_run(input int n, input logic [1:0] lvl, input logic chg, input string req);
        for (int i = 0; i < n - 1; i++) begin
            ins_valid = 1'b0;
            @(negedge clk);
        end
        drive(1'b0, 2'b00, 1'b0, lvl, chg, req);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog cyc=%0d level=%0d exp=done", cyc, lic_level);
        summary();
    end

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; cfg_disable = 1'b0;
        cfg_thresh = 8'd0; cfg_quiet = 16'd0;
        ins_valid = 1'b0; ins_width = 2'b00; ins_heavy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 2'b00, 1'b0, 2'd0, 1'b0, "R1 reset");

        // R1/R4 default threshold 16 on heavy 256
        rep(15, 2'b01, 1'b1, 2'd0, "R4 default below threshold");
        drive(1'b1, 2'b01, 1'b1, 2'd1, 1'b1, "R1 R4 sixteenth raises");
        // R1/R6 default quiet 1024
        quiet_run(1023, 2'd1, 1'b0, "R6 hold before quiet end");
        quiet_run(1, 2'd0, 1'b1, "R1 R6 drop at 1024");
        drive(1'b0, 2'b00, 1'b0, 2'd0, 1'b0, "R10 strobe one cycle");

        // R11 load threshold 3, quiet 8
        cfg_thresh = 8'd3; cfg_quiet = 16'd8; cfg_load = 1'b1;
        drive(1'b0, 2'b00, 1'b0, 2'd0, 1'b0, "R11 load");
        cfg_load = 1'b0;

        // R2 passive classes
        rep(4, 2'b00, 1'b0, 2'd0, "R2 128 light");
        rep(4, 2'b00, 1'b1, 2'd0, "R2 128 heavy");
        rep(4, 2'b01, 1'b0, 2'd0, "R2 256 light");
        rep(4, 2'b11, 1'b1, 2'd0, "R2 reserved width");

        // R3 hard raise, passives do not restart quiet (R2)
        drive(1'b1, 2'b10, 1'b0, 2'd1, 1'b1, "R3 light 512 hard raise");
        rep(7, 2'b00, 1'b1, 2'd1, "R2 passive at level 1");
        drive(1'b1, 2'b01, 1'b0, 2'd0, 1'b1, "R2 R11 quiet 8 ignores passives");

        // R4 threshold 3
        rep(2, 2'b01, 1'b1, 2'd0, "R4 below threshold 3");
        drive(1'b1, 2'b01, 1'b1, 2'd1, 1'b1, "R4 third raises");
        // R5 from level 1
        rep(2, 2'b10, 1'b1, 2'd1, "R5 below threshold at level 1");
        drive(1'b1, 2'b10, 1'b1, 2'd2, 1'b1, "R5 raise to level 2");

        // R7 light 512 does not hold level 2, but holds level 1
        rep(7, 2'b10, 1'b0, 2'd2, "R7 level 2 during quiet");
        drive(1'b1, 2'b10, 1'b0, 2'd1, 1'b1, "R7 drop to level 1");
        rep(5, 2'b10, 1'b0, 2'd1, "R7 light 512 holds level 1");
        quiet_run(7, 2'd1, 1'b0, "R6 level 1 before quiet end");
        quiet_run(1, 2'd0, 1'b1, "R6 drop to level 0");

        // R5 direct from level 0, R6 two single steps
        rep(2, 2'b10, 1'b1, 2'd0, "R5 below threshold at level 0");
        drive(1'b1, 2'b10, 1'b1, 2'd2, 1'b1, "R5 direct raise to level 2");
        quiet_run(8, 2'd1, 1'b1, "R6 step 2 to 1");
        quiet_run(8, 2'd0, 1'b1, "R6 step 1 to 0");

        // R8 level-0 expiry clears the count
        rep(2, 2'b01, 1'b1, 2'd0, "R8 partial count");
        quiet_run(8, 2'd0, 1'b0, "R8 level 0 expiry");
        rep(2, 2'b01, 1'b1, 2'd0, "R8 count restarted");
        drive(1'b1, 2'b01, 1'b1, 2'd1, 1'b1, "R8 raise after fresh count");
        quiet_run(8, 2'd0, 1'b1, "R6 back to 0");

        // R8 level change clears the heavy 512 count
        rep(2, 2'b10, 1'b1, 2'd0, "R8 partial 512 count");
        drive(1'b1, 2'b10, 1'b0, 2'd1, 1'b1, "R8 R3 hard raise clears");
        rep(2, 2'b10, 1'b1, 2'd1, "R8 count restarted at level 1");
        drive(1'b1, 2'b10, 1'b1, 2'd2, 1'b1, "R8 raise after fresh count");
        quiet_run(8, 2'd1, 1'b1, "R6 step down");
        quiet_run(8, 2'd0, 1'b1, "R6 step down");

        // R9 disable
        drive(1'b1, 2'b10, 1'b0, 2'd1, 1'b1, "R9 setup raise");
        cfg_disable = 1'b1;
        drive(1'b0, 2'b00, 1'b0, 2'd0, 1'b1, "R9 forced to 0");
        rep(3, 2'b10, 1'b0, 2'd0, "R9 light 512 blocked");
        rep(4, 2'b10, 1'b1, 2'd0, "R9 heavy 512 blocked");
        rep(4, 2'b01, 1'b1, 2'd0, "R9 heavy 256 blocked");
        cfg_disable = 1'b0;
        drive(1'b1, 2'b10, 1'b0, 2'd1, 1'b1, "R9 release allows raise");
        quiet_run(8, 2'd0, 1'b1, "R6 final drop");

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R10 pending=%0d exp=0", sb.size());
        end
        summary();
    end
endmodule